// File: doc/BRIEF.md
# Bus Mastership Request and Grant Controller

This block runs the module side of the handshake for gaining bus mastership. A requester asserts one or both of two active-low request lines. Each line has its own 8-bit priority value, and the block presents the selected value to an external competition circuit as the contest number. When that circuit reports a win, the block grants bus tenure. If a module of higher priority later becomes master elect, the block raises a preemption signal so that the current master knows it must finish and give up the bus. Grant and preemption drop together once both request lines are released. A new contest can start only when grant and preemption are both low.

The operating mode is taken from the preemption line while the system reset input is high. A high level selects central operation and a low level selects distributed operation. In central operation both the grant driver and the preemption driver are disabled (high impedance) and the handshake engine stays idle. The sequencer has four states. IDLE moves to COMPETE on any asserted request (transition *start*). COMPETE moves to MASTER on a win strobe (*win*). MASTER moves to PREEMPT on a higher-priority-elect strobe (*preempt*). MASTER and PREEMPT both return to IDLE when both requests are released (*release*). Module reset and system reset force IDLE.

Top module: `mastership_handshake`

## Requirements
- R1: After module reset, grant, preempt and compete are low, the contest number is 0, the violation flag is clear, distributed mode is selected and both output enables are high.
- R2: With only request 0 asserted (req_n = 2'b10) in IDLE, compete rises one cycle later and the contest number equals prio0. With only request 1 asserted (req_n = 2'b01), the contest number equals prio1.
- R3: With both requests asserted (req_n = 2'b00) in IDLE, the contest number equals the larger of prio0 and prio1.
- R4: A win strobe seen in COMPETE raises grant and drops compete one cycle later. A win strobe in IDLE has no effect.
- R5: Grant stays high while either request is asserted. It drops one cycle after the cycle in which both requests are released (req_n = 2'b11).
- R6: An elect strobe seen in MASTER raises preempt one cycle later, and grant stays high. An elect strobe in IDLE or COMPETE has no effect.
- R7: Preempt drops in the same cycle as grant, when both requests are released.
- R8: A request line that goes from released to asserted while grant or preempt is high sets the violation flag one cycle later. It has no effect on grant. The flag stays set until a module or system reset.
- R9: The preempt line level sampled while sys_reset is high selects the mode: 1 selects central, 0 selects distributed. In central mode both output enables are low, and requests and win strobes leave compete and grant low.
- R10: While sys_reset is high, both output enables are low. The sequencer returns to IDLE and the violation flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low module reset |
| sys_reset | input | 1 | System reset; the mode is sampled while this is high |
| pe_line_in | input | 1 | Level of the preemption bus line, used for mode sampling |
| req_n | input | 2 | Active-low requests; bit 0 is request 0, bit 1 is request 1 |
| prio0 | input | 8 | Priority value tied to request 0 |
| prio1 | input | 8 | Priority value tied to request 1 |
| win | input | 1 | Strobe from the competition logic: contest won |
| elect | input | 1 | Strobe: a higher-priority module became master elect |
| contest_num | output | 8 | Priority value presented to the contest |
| compete_o | output | 1 | Contest in progress |
| grant_o | output | 1 | Mastership granted; tenure may begin |
| grant_oe | output | 1 | Driver enable for grant_o (low means high impedance) |
| preempt_o | output | 1 | Preemption indication |
| preempt_oe | output | 1 | Driver enable for preempt_o (low means high impedance) |
| central_mode | output | 1 | Central operation is in effect |
| proto_err | output | 1 | Sticky request-ordering violation flag |

## Verification
Every sequencer output is a Moore output of one state register, so compete, grant, preempt, the contest number and the violation flag each change exactly one clock edge after the input that causes them. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares all outputs on the next falling edge. Each vector's expected values therefore describe the state after that single edge. The output enables follow sys_reset without a register, so they are checked in the same half-cycle in which sys_reset is driven. The mode flag is checked one edge after sys_reset.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
    localparam int REQ_LINES = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPETE = 2'd1,
        ST_MASTER  = 2'd2,
        ST_PREEMPT = 2'd3
    } mbr_state_e;
endpackage

// File: rtl/mbr_mode_latch.sv
module mbr_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_reset,
    input  logic pe_line_in,
    output logic central
);
    // Mode follows the sampled preemption line for as long as system reset is held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            central <= 1'b0;
        else if (sys_reset)
            central <= pe_line_in;
    end
endmodule

// File: rtl/mbr_prio_pick.sv
module mbr_prio_pick #(
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_reset,
    input  logic [1:0]        req_act,
    input  logic              load,
    input  logic [PRIO_W-1:0] prio0,
    input  logic [PRIO_W-1:0] prio1,
    output logic [PRIO_W-1:0] num_q
);
    logic [PRIO_W-1:0] larger;
    logic [PRIO_W-1:0] chosen;

    assign larger = (prio1 > prio0) ? prio1 : prio0;

    always_comb begin
        unique case (req_act)
            2'b11:   chosen = larger;
            2'b10:   chosen = prio1;
            default: chosen = prio0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            num_q <= '0;
        else if (sys_reset)
            num_q <= '0;
        else if (load)
            num_q <= chosen;
    end
endmodule

// File: rtl/mbr_fsm.sv
module mbr_fsm
    import mbr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sys_reset,
    input  logic                 central,
    input  logic [REQ_LINES-1:0] req_act,
    input  logic                 win,
    input  logic                 elect,
    output logic                 grant,
    output logic                 preempt,
    output logic                 compete,
    output logic                 load,
    output logic                 proto_err
);
    mbr_state_e state_q, state_d;
    logic [REQ_LINES-1:0] req_q;
    logic [REQ_LINES-1:0] rose;
    logic any_req;

    assign any_req = |req_act;
    assign rose    = req_act & ~req_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (sys_reset)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions: start, win, preempt, release
    always_comb begin
        state_d = state_q;
        if (central) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (any_req) state_d = ST_COMPETE;
                ST_COMPETE: if (win)     state_d = ST_MASTER;
                ST_MASTER: begin
                    if (!any_req)    state_d = ST_IDLE;
                    else if (elect)  state_d = ST_PREEMPT;
                end
                ST_PREEMPT: if (!any_req) state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        grant   = 1'b0;
        preempt = 1'b0;
        compete = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_COMPETE: compete = 1'b1;
            ST_MASTER:  grant   = 1'b1;
            ST_PREEMPT: begin
                grant   = 1'b1;
                preempt = 1'b1;
            end
            default:    ;
        endcase
    end

    assign load = (state_q == ST_IDLE) && any_req && !central;

    // Request edge history and sticky ordering-violation flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q     <= '0;
            proto_err <= 1'b0;
        end else if (sys_reset) begin
            req_q     <= req_act;
            proto_err <= 1'b0;
        end else begin
            req_q <= req_act;
            if (!central && (|rose) && (grant || preempt))
                proto_err <= 1'b1;
        end
    end
endmodule

// File: rtl/mastership_handshake.sv
module mastership_handshake #(
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_reset,
    input  logic              pe_line_in,
    input  logic [1:0]        req_n,
    input  logic [PRIO_W-1:0] prio0,
    input  logic [PRIO_W-1:0] prio1,
    input  logic              win,
    input  logic              elect,
    output logic [PRIO_W-1:0] contest_num,
    output logic              compete_o,
    output logic              grant_o,
    output logic              grant_oe,
    output logic              preempt_o,
    output logic              preempt_oe,
    output logic              central_mode,
    output logic              proto_err
);
    logic [1:0] req_act;
    logic       load;

    assign req_act = ~req_n;

    mbr_mode_latch u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_reset (sys_reset),
        .pe_line_in(pe_line_in),
        .central   (central_mode)
    );

    mbr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_reset(sys_reset),
        .central  (central_mode),
        .req_act  (req_act),
        .win      (win),
        .elect    (elect),
        .grant    (grant_o),
        .preempt  (preempt_o),
        .compete  (compete_o),
        .load     (load),
        .proto_err(proto_err)
    );

    mbr_prio_pick #(.PRIO_W(PRIO_W)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_reset(sys_reset),
        .req_act  (req_act),
        .load     (load),
        .prio0    (prio0),
        .prio1    (prio1),
        .num_q    (contest_num)
    );

    // Drivers are released in central mode and while the mode is being sampled
    assign grant_oe   = !central_mode && !sys_reset;
    assign preempt_oe = !central_mode && !sys_reset;
endmodule

// File: rtl/mastership_handshake_chk.sv
module mastership_handshake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_reset,
    input logic [1:0] req_n,
    input logic       win,
    input logic       compete_o,
    input logic       grant_o,
    input logic       grant_oe,
    input logic       preempt_o,
    input logic       preempt_oe,
    input logic       central_mode,
    input logic       proto_err
);
    // R4: grant rises only after a win while competing
    a_r4_grant_after_win: assert property (@(posedge clk) disable iff (!rst_n || sys_reset)
        $rose(grant_o) |-> $past(win && compete_o));

    // R5: grant falls only after both requests were released
    a_r5_release_order: assert property (@(posedge clk) disable iff (!rst_n || sys_reset)
        ($fell(grant_o) && !$past(sys_reset)) |-> ($past(req_n) == 2'b11));

    // R6: preemption is only shown by the current master
    a_r6_pe_needs_grant: assert property (@(posedge clk) disable iff (!rst_n || sys_reset)
        preempt_o |-> grant_o);

    // R7: preemption and grant drop together
    a_r7_pe_with_grant: assert property (@(posedge clk) disable iff (!rst_n || sys_reset)
        ($fell(preempt_o) && !$past(sys_reset)) |-> $fell(grant_o));

    // R8: violation flag is sticky
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n || sys_reset)
        ($past(proto_err) && !$past(sys_reset)) |-> proto_err);

    // R9: central mode keeps both drivers off and the sequencer quiet
    a_r9_central_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        central_mode |-> (!grant_oe && !preempt_oe && !grant_o && !compete_o));
endmodule

bind mastership_handshake mastership_handshake_chk u_chk (.*);

// File: tb/mastership_handshake_test.sv
module mastership_handshake_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_reset = 1'b0;
    logic       pe_line_in = 1'b0;
    logic [1:0] req_n = 2'b11;
    logic [7:0] prio0 = 8'h30;
    logic [7:0] prio1 = 8'hA5;
    logic       win = 1'b0;
    logic       elect = 1'b0;
    logic [7:0] contest_num;
    logic       compete_o, grant_o, grant_oe, preempt_o, preempt_oe, central_mode, proto_err;

    int applied = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    mastership_handshake uut (
        .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .pe_line_in(pe_line_in),
        .req_n(req_n), .prio0(prio0), .prio1(prio1), .win(win), .elect(elect),
        .contest_num(contest_num), .compete_o(compete_o), .grant_o(grant_o),
        .grant_oe(grant_oe), .preempt_o(preempt_o), .preempt_oe(preempt_oe),
        .central_mode(central_mode), .proto_err(proto_err)
    );

    // {req_n[1:0], win, elect, exp_grant, exp_preempt, exp_compete, exp_num[7:0]}
    localparam int NV = 16;
    localparam logic [14:0] VEC [NV] = '{
        {2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R4 win ignored in IDLE
        {2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R6 elect ignored in IDLE
        {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h30}, // R2 request 0
        {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h30}, // R6 elect ignored in COMPETE
        {2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h30}, // R4 win
        {2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h30}, // R5 held
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h30}, // R5 release
        {2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5}, // R2 request 1
        {2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5}, // R4 win
        {2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hA5}, // R6 preempt
        {2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hA5}, // R6 stays
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5}, // R7 drops with grant
        {2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5}, // R3 both, prio1 larger
        {2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5}, // R4 win
        {2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA5}, // R5 one line still held
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5}  // R5 release
    };

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        applied++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] r, input logic w, input logic e);
        req_n = r; win = w; elect = e;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            applied++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "grant",   {7'd0, grant_o},      8'd0);
        check("R1", "preempt", {7'd0, preempt_o},    8'd0);
        check("R1", "compete", {7'd0, compete_o},    8'd0);
        check("R1", "num",     contest_num,          8'd0);
        check("R1", "err",     {7'd0, proto_err},    8'd0);
        check("R1", "central", {7'd0, central_mode}, 8'd0);
        check("R1", "oe",      {6'd0, grant_oe, preempt_oe}, 8'd3);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][14:13], VEC[i][12], VEC[i][11]);
            check("R2-table", $sformatf("v%0d grant", i),   {7'd0, grant_o},   {7'd0, VEC[i][10]});
            check("R6-table", $sformatf("v%0d preempt", i), {7'd0, preempt_o}, {7'd0, VEC[i][9]});
            check("R4-table", $sformatf("v%0d compete", i), {7'd0, compete_o}, {7'd0, VEC[i][8]});
            check("R3-table", $sformatf("v%0d num", i),     contest_num,       VEC[i][7:0]);
            check("R8-table", $sformatf("v%0d err", i),     {7'd0, proto_err}, 8'd0);
        end

        // R3 both requests with prio0 larger
        prio0 = 8'hC0; prio1 = 8'h10;
        step(2'b00, 1'b0, 1'b0);
        check("R3", "num prio0 larger", contest_num, 8'hC0);
        step(2'b00, 1'b1, 1'b0);
        check("R4", "grant", {7'd0, grant_o}, 8'd1);

        // R8 a request line rises while grant is high
        step(2'b10, 1'b0, 1'b0);
        check("R8", "no flag on release", {7'd0, proto_err}, 8'd0);
        step(2'b00, 1'b0, 1'b0);
        check("R8", "flag set", {7'd0, proto_err}, 8'd1);
        check("R8", "grant unaffected", {7'd0, grant_o}, 8'd1);
        check("R8", "num unaffected", contest_num, 8'hC0);
        step(2'b11, 1'b0, 1'b0);
        check("R5", "grant dropped", {7'd0, grant_o}, 8'd0);
        step(2'b11, 1'b0, 1'b0);
        check("R8", "flag sticky", {7'd0, proto_err}, 8'd1);

        // R9/R10 system reset with preempt line high selects central mode
        sys_reset = 1'b1; pe_line_in = 1'b1;
        #1;
        check("R10", "oe during sys_reset", {6'd0, grant_oe, preempt_oe}, 8'd0);
        @(negedge clk);
        sys_reset = 1'b0; pe_line_in = 1'b0;
        check("R9", "central", {7'd0, central_mode}, 8'd1);
        check("R10", "flag cleared", {7'd0, proto_err}, 8'd0);
        check("R9", "oe in central", {6'd0, grant_oe, preempt_oe}, 8'd0);
        step(2'b10, 1'b0, 1'b0);
        check("R9", "no compete in central", {7'd0, compete_o}, 8'd0);
        step(2'b10, 1'b1, 1'b0);
        check("R9", "no grant in central", {7'd0, grant_o}, 8'd0);
        step(2'b11, 1'b0, 1'b0);

        // R9 back to distributed
        sys_reset = 1'b1; pe_line_in = 1'b0;
        @(negedge clk);
        sys_reset = 1'b0;
        #1;
        check("R9", "distributed", {7'd0, central_mode}, 8'd0);
        check("R9", "oe restored", {6'd0, grant_oe, preempt_oe}, 8'd3);
        @(negedge clk);
        step(2'b01, 1'b0, 1'b0);
        check("R2", "req1 after mode switch", contest_num, 8'h10);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end
endmodule